// File: doc/BRIEF.md
# Packet Buffer Page Allocator with Transmit Reservation

This block keeps track of which pages of a shared packet buffer are free. The buffer is divided into 64 pages of 2 KB each, 128 KB in total. A transmit path and a receive path can each request a page. The block answers every request one cycle later with either a grant, which carries the lowest-numbered free page, or a deny. Pages come back to the pool through a release port. A soft reset returns every page to the pool at once.

Memory amounts are counted in units of 512 bytes: a base unit of 256 bytes times a fixed size multiplier of 2. One page is therefore 4 units. Software writes a reservation amount that holds memory back for transmit alone. Receive requests are refused while free memory is not strictly greater than the reservation. Transmit requests ignore the reservation. The reservation is measured against whatever memory is free at the moment, so it does not shrink as transmit takes pages. Software that wants a fixed transmit share must rewrite the reservation as pages are allocated and released.

A small register port lets software write the reservation and read back both the reservation and the free amount.

Top module: `pga_top`

## Requirements
- R1: After hardware reset, reading register select 1 returns 256 (the free amount in units), and reading register select 0 returns 0x0200. The upper byte is the size multiplier 2 and the lower byte is the reservation, which resets to 0.
- R2: Register select 1 reads back the free amount as 4 units per free page, in bits [8:0], with zeros above. A read returns data one cycle after `rd_sel` is sampled.
- R3: A transmit request is granted whenever at least one page is free, whatever the reservation. The grant returns the lowest-numbered free page on `tx_page`. The request is denied only when no page is free.
- R4: With a reservation of 0, a receive request is granted whenever a page is free, and the grant returns the lowest-numbered free page.
- R5: With a nonzero reservation R (in units), a receive request is granted only if the free units left after any same-cycle transmit grant are strictly greater than R. Otherwise it is denied.
- R6: A reservation byte of 0xFF counts as 256 units. With that value, every receive request is denied, even with the whole buffer free.
- R7: When transmit and receive request in the same cycle, transmit is served first and gets the lowest free page. Receive then gets the next-lowest free page, or a deny if no page is left.
- R8: A release of an allocated page returns it to the pool and adds 4 units to the free amount. A release of a page that is already free changes nothing.
- R9: A release in the same cycle as a grant is accounted correctly: the free amount changes by the number of pages released minus the number granted. The released page is not granted in that same cycle.
- R10: A soft reset makes all 64 pages free in one cycle and leaves the reservation unchanged. Requests made in the soft-reset cycle are denied.
- R11: Register writes to select 0 change only the lower byte. The upper byte always reads back as 0x02. Writes to select 1 have no effect.
- R12: Each request gets exactly one response, a grant or a deny, in the cycle after it is made. No response appears without a request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high hardware reset |
| soft_rst | input | 1 | Return all pages to the pool; the reservation is kept |
| tx_req | input | 1 | Transmit page request, one-cycle pulse |
| tx_gnt | output | 1 | Transmit grant, one cycle after the request |
| tx_deny | output | 1 | Transmit deny, one cycle after the request |
| tx_page | output | 6 | Granted transmit page index |
| rx_req | input | 1 | Receive page request, one-cycle pulse |
| rx_gnt | output | 1 | Receive grant, one cycle after the request |
| rx_deny | output | 1 | Receive deny, one cycle after the request |
| rx_page | output | 6 | Granted receive page index |
| rel_vld | input | 1 | Page release strobe |
| rel_page | input | 6 | Index of the released page |
| wr_en | input | 1 | Register write enable |
| wr_sel | input | 1 | Write select: 0 = reservation |
| wr_data | input | 16 | Write data; only bits [7:0] are stored |
| rd_sel | input | 1 | Read select: 0 = reservation/multiplier, 1 = free units |
| rd_data | output | 16 | Registered read data |

## Verification
The bench sweeps every free-page count from 0 to 64 against several reservations. These include 0, small and large multiples of 4, and 0xFF. A design that used "greater or equal" instead of "strictly greater", or that read 0xFF as 255, would grant a receive request exactly at the boundary. Simultaneous requests are checked with one page left, and at a reservation edge where the transmit grant pushes receive below the threshold. A design that judged receive on the count before the transmit grant would grant there wrongly. Double releases, a release in the same cycle as a grant, soft reset with a nonzero reservation, and writes to the read-only upper byte are also covered. These catch a free count that drifts, a page handed out twice, or a reservation lost on soft reset.

// File: rtl/pga_pkg.sv
`timescale 1ns/1ps
package pga_pkg;
  // Register selects on the software port
  localparam logic SEL_RESV = 1'b0;
  localparam logic SEL_FREE = 1'b1;
endpackage

// File: rtl/pga_lowest.sv
`timescale 1ns/1ps
// Finds the lowest set bit of a vector.
module pga_lowest #(
  parameter int W  = 64,
  parameter int IW = $clog2(W)
) (
  input  logic [W-1:0]  vec,
  output logic [IW-1:0] idx,
  output logic          found
);
  always_comb begin
    idx   = '0;
    found = 1'b0;
    for (int i = W - 1; i >= 0; i--) begin
      if (vec[i]) begin
        idx   = IW'(i);
        found = 1'b1;
      end
    end
  end
endmodule

// File: rtl/pga_pool.sv
`timescale 1ns/1ps
// Free-page bitmap and free-page counter, with two lowest-free candidates.
module pga_pool #(
  parameter int N  = 64,
  parameter int PW = $clog2(N),
  parameter int CW = $clog2(N + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          soft_rst,
  input  logic          take_first,
  input  logic          take_second,
  input  logic          rel_vld,
  input  logic [PW-1:0] rel_page,
  output logic [CW-1:0] free_pages,
  output logic [PW-1:0] first_idx,
  output logic          first_ok,
  output logic [PW-1:0] second_idx,
  output logic          second_ok
);
  logic [N-1:0]  free_q, free_d, mask;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          rel_hit;

  pga_lowest #(.W(N), .IW(PW)) u_first (
    .vec(free_q), .idx(first_idx), .found(first_ok)
  );

  assign mask = free_q & ~({{(N-1){1'b0}}, 1'b1} << first_idx);

  pga_lowest #(.W(N), .IW(PW)) u_second (
    .vec(mask), .idx(second_idx), .found(second_ok)
  );

  assign rel_hit = rel_vld && !free_q[rel_page];

  always_comb begin
    free_d = free_q;
    if (take_first)  free_d[first_idx]  = 1'b0;
    if (take_second) free_d[second_idx] = 1'b0;
    if (rel_hit)     free_d[rel_page]   = 1'b1;
    cnt_d = cnt_q - CW'(take_first) - CW'(take_second) + CW'(rel_hit);
  end

  always_ff @(posedge clk) begin
    if (rst || soft_rst) begin
      free_q <= '1;
      cnt_q  <= CW'(N);
    end else begin
      free_q <= free_d;
      cnt_q  <= cnt_d;
    end
  end

  assign free_pages = cnt_q;
endmodule

// File: rtl/pga_regs.sv
`timescale 1ns/1ps
// Reservation register and registered readback.
module pga_regs
  import pga_pkg::*;
#(
  parameter int REG_W = 8,
  parameter int MULT  = 2,
  parameter int UW    = 9,
  parameter int RW    = REG_W + 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic             wr_sel,
  input  logic [2*REG_W-1:0] wr_data,
  input  logic             rd_sel,
  input  logic [UW-1:0]    free_units,
  output logic [2*REG_W-1:0] rd_data,
  output logic [RW-1:0]    resv_units
);
  logic [REG_W-1:0] resv_q;
  logic             unused_hi;

  assign unused_hi = ^wr_data[2*REG_W-1:REG_W];

  always_ff @(posedge clk) begin
    if (rst) resv_q <= '0;
    else if (wr_en && wr_sel == SEL_RESV) resv_q <= wr_data[REG_W-1:0];
  end

  // All-ones stands for the full 2^REG_W units
  assign resv_units = (resv_q == '1) ? RW'(1 << REG_W) : RW'(resv_q);

  always_ff @(posedge clk) begin
    if (rst) rd_data <= '0;
    else if (rd_sel == SEL_RESV) rd_data <= {REG_W'(MULT), resv_q};
    else rd_data <= (2*REG_W)'(free_units);
  end
endmodule

// File: rtl/pga_top.sv
`timescale 1ns/1ps
module pga_top #(
  parameter int NUM_PAGES = 64,
  parameter int UPP       = 4,
  parameter int REG_W     = 8,
  parameter int MULT      = 2,
  localparam int PW       = $clog2(NUM_PAGES),
  localparam int CW       = $clog2(NUM_PAGES + 1),
  localparam int UW       = $clog2(NUM_PAGES * UPP + 1),
  localparam int RW       = REG_W + 1,
  localparam int DW       = 2 * REG_W
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          soft_rst,
  input  logic          tx_req,
  output logic          tx_gnt,
  output logic          tx_deny,
  output logic [PW-1:0] tx_page,
  input  logic          rx_req,
  output logic          rx_gnt,
  output logic          rx_deny,
  output logic [PW-1:0] rx_page,
  input  logic          rel_vld,
  input  logic [PW-1:0] rel_page,
  input  logic          wr_en,
  input  logic          wr_sel,
  input  logic [DW-1:0] wr_data,
  input  logic          rd_sel,
  output logic [DW-1:0] rd_data
);
  localparam int CMPW = (UW > RW) ? UW : RW;

  logic [CW-1:0] free_pages;
  logic [PW-1:0] first_idx, second_idx, rx_idx;
  logic          first_ok, second_ok;
  logic [RW-1:0] resv_units;
  logic [UW-1:0] free_units;
  logic          tx_ok, rx_ok, rx_cand, rx_allow;
  logic [CMPW-1:0] avail_units;

  assign free_units = UW'(free_pages) * UW'(UPP);

  // Transmit first; receive uses whatever is left
  assign tx_ok       = tx_req && !soft_rst && first_ok;
  assign rx_cand     = tx_ok ? second_ok : first_ok;
  assign rx_idx      = tx_ok ? second_idx : first_idx;
  assign avail_units = CMPW'(free_pages - CW'(tx_ok)) * CMPW'(UPP);
  assign rx_allow    = (resv_units == '0) || (avail_units > CMPW'(resv_units));
  assign rx_ok       = rx_req && !soft_rst && rx_cand && rx_allow;

  pga_pool #(.N(NUM_PAGES), .PW(PW), .CW(CW)) u_pool (
    .clk(clk), .rst(rst), .soft_rst(soft_rst),
    .take_first(tx_ok || rx_ok), .take_second(tx_ok && rx_ok),
    .rel_vld(rel_vld && !soft_rst), .rel_page(rel_page),
    .free_pages(free_pages),
    .first_idx(first_idx), .first_ok(first_ok),
    .second_idx(second_idx), .second_ok(second_ok)
  );

  pga_regs #(.REG_W(REG_W), .MULT(MULT), .UW(UW), .RW(RW)) u_regs (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .rd_sel(rd_sel), .free_units(free_units), .rd_data(rd_data),
    .resv_units(resv_units)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      tx_gnt  <= 1'b0;
      tx_deny <= 1'b0;
      tx_page <= '0;
      rx_gnt  <= 1'b0;
      rx_deny <= 1'b0;
      rx_page <= '0;
    end else begin
      tx_gnt  <= tx_ok;
      tx_deny <= tx_req && !tx_ok;
      rx_gnt  <= rx_ok;
      rx_deny <= rx_req && !rx_ok;
      if (tx_ok) tx_page <= first_idx;
      if (rx_ok) rx_page <= rx_idx;
    end
  end
endmodule

// File: rtl/pga_chk.sv
`timescale 1ns/1ps
module pga_chk #(
  parameter int NUM_PAGES = 64,
  parameter int UPP       = 4,
  parameter int CW        = 7,
  parameter int RW        = 9
) (
  input logic          clk,
  input logic          rst,
  input logic          soft_rst,
  input logic          wr_en,
  input logic          tx_req,
  input logic          rx_req,
  input logic          tx_gnt,
  input logic          tx_deny,
  input logic          rx_gnt,
  input logic          rx_deny,
  input logic [CW-1:0] free_pages,
  input logic [RW-1:0] resv_units
);
  localparam int AW = CW + RW + 2;

  AST_TX_ONE_RESP: assert property (@(posedge clk) disable iff (rst)
    !(tx_gnt && tx_deny)) else $error("tx both"); // R12
  AST_RX_ONE_RESP: assert property (@(posedge clk) disable iff (rst)
    !(rx_gnt && rx_deny)) else $error("rx both"); // R12
  AST_TX_RESP_REQ: assert property (@(posedge clk) disable iff (rst)
    (tx_gnt || tx_deny) |-> $past(tx_req)) else $error("tx stray"); // R12
  AST_RX_RESP_REQ: assert property (@(posedge clk) disable iff (rst)
    (rx_gnt || rx_deny) |-> $past(rx_req)) else $error("rx stray"); // R12
  AST_TX_DENY_EMPTY: assert property (@(posedge clk) disable iff (rst)
    (tx_deny && !$past(soft_rst)) |-> ($past(free_pages) == '0)) else $error("tx deny"); // R3
  AST_RX_OVER_RESV: assert property (@(posedge clk) disable iff (rst)
    rx_gnt |-> (($past(resv_units) == '0) ||
      (AW'($past(free_pages)) * AW'(UPP) > AW'($past(resv_units))))) else $error("rx resv"); // R5
  AST_SOFT_FULL: assert property (@(posedge clk) disable iff (rst)
    $past(soft_rst) |-> (free_pages == CW'(NUM_PAGES))) else $error("soft"); // R10
  AST_SOFT_KEEP_RESV: assert property (@(posedge clk) disable iff (rst)
    (soft_rst && !wr_en) |=> $stable(resv_units)) else $error("resv lost"); // R10
  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
    free_pages <= CW'(NUM_PAGES)) else $error("overflow"); // R8
endmodule

bind pga_top pga_chk #(.NUM_PAGES(NUM_PAGES), .UPP(UPP), .CW(CW), .RW(RW)) u_chk (
  .clk(clk), .rst(rst), .soft_rst(soft_rst), .wr_en(wr_en),
  .tx_req(tx_req), .rx_req(rx_req), .tx_gnt(tx_gnt), .tx_deny(tx_deny),
  .rx_gnt(rx_gnt), .rx_deny(rx_deny), .free_pages(free_pages),
  .resv_units(resv_units)
);

// File: tb/pga_top_tb_top.sv
`timescale 1ns/1ps
module pga_top_tb_top;
  logic clk = 1'b0, rst = 1'b1, soft_rst = 1'b0;
  logic tx_req = 1'b0, rx_req = 1'b0, rel_vld = 1'b0;
  logic [5:0] rel_page = '0;
  logic wr_en = 1'b0, wr_sel = 1'b0, rd_sel = 1'b0;
  logic [15:0] wr_data = '0;
  logic tx_gnt, tx_deny, rx_gnt, rx_deny;
  logic [5:0] tx_page, rx_page;
  logic [15:0] rd_data;

  int nchk = 0, nerr = 0;
  bit mfree [64];
  int resv_u = 0;

  always #10 clk = ~clk;

  pga_top dut_i (
    .clk(clk), .rst(rst), .soft_rst(soft_rst),
    .tx_req(tx_req), .tx_gnt(tx_gnt), .tx_deny(tx_deny), .tx_page(tx_page),
    .rx_req(rx_req), .rx_gnt(rx_gnt), .rx_deny(rx_deny), .rx_page(rx_page),
    .rel_vld(rel_vld), .rel_page(rel_page),
    .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .rd_sel(rd_sel), .rd_data(rd_data)
  );

  task automatic chk(input string tag, input int act, input int exp);
    nchk++;
    if (act != exp) begin
      nerr++;
      $display("FAIL %s act=%0d exp=%0d", tag, act, exp);
    end
  endtask

  function automatic int nfree();
    int n = 0;
    for (int i = 0; i < 64; i++) n += int'(mfree[i]);
    return n;
  endfunction

  task automatic model_reset();
    for (int i = 0; i < 64; i++) mfree[i] = 1'b1;
  endtask

  task automatic rd(input bit sel, output int v);
    rd_sel = sel;
    @(negedge clk);
    v = int'(rd_data);
  endtask

  task automatic wr(input bit sel, input int v);
    wr_en = 1'b1; wr_sel = sel; wr_data = 16'(v);
    @(negedge clk);
    wr_en = 1'b0;
    if (sel == 1'b0) resv_u = ((v & 255) == 255) ? 256 : (v & 255);
  endtask

  // One cycle of stimulus with an independent expectation model
  task automatic step(input bit t, input bit r, input bit rl, input int rp,
                      input bit srst, input string tag);
    int first = -1, second = -1, rc, after;
    bit et, er, hit;
    for (int i = 0; i < 64; i++)
      if (mfree[i]) begin
        if (first < 0) first = i;
        else if (second < 0) second = i;
      end
    et = t && !srst && first >= 0;
    rc = et ? second : first;
    after = nfree() - int'(et);
    er = r && !srst && rc >= 0 && (resv_u == 0 || after * 4 > resv_u);
    hit = rl && !srst && !mfree[rp];
    tx_req = t; rx_req = r; rel_vld = rl; rel_page = 6'(rp); soft_rst = srst;
    @(negedge clk);
    tx_req = 1'b0; rx_req = 1'b0; rel_vld = 1'b0; soft_rst = 1'b0;
    if (t) begin
      chk({tag, " tx_gnt"}, int'(tx_gnt), int'(et));
      chk({tag, " tx_deny"}, int'(tx_deny), int'(!et));
      if (et) chk({tag, " tx_page"}, int'(tx_page), first);
    end
    if (r) begin
      chk({tag, " rx_gnt"}, int'(rx_gnt), int'(er));
      chk({tag, " rx_deny"}, int'(rx_deny), int'(!er));
      if (er) chk({tag, " rx_page"}, int'(rx_page), rc);
    end
    if (srst) model_reset();
    else begin
      if (et) mfree[first] = 1'b0;
      if (er) mfree[rc] = 1'b0;
      if (hit) mfree[rp] = 1'b1;
    end
  endtask

  task automatic fill_to(input int f);
    step(0, 0, 0, 0, 1, "R10 srst");
    for (int k = 0; k < 64 - f; k++) step(1, 0, 0, 0, 0, "R3 fill");
  endtask

  initial begin
    int v;
    int rlist [7] = '{0, 4, 8, 60, 128, 252, 255};
    model_reset();
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    // R1 reset state
    rd(1'b1, v); chk("R1 free units", v, 256);
    rd(1'b0, v); chk("R1 resv reg", v, 16'h0200);

    // R3 full transmit drain, then deny when empty
    for (int k = 0; k < 64; k++) step(1, 0, 0, 0, 0, "R3 drain");
    step(1, 0, 0, 0, 0, "R3 empty");
    step(0, 1, 0, 0, 0, "R4 empty rx");
    rd(1'b1, v); chk("R2 free zero", v, 0);

    // R5/R6/R4 sweep of free count against reservation
    foreach (rlist[j]) begin
      wr(1'b0, rlist[j]);
      for (int f = 0; f <= 64; f++) begin
        fill_to(f);
        rd(1'b1, v); chk("R2 free units", v, f * 4);
        step(0, 1, 0, 0, 0, (rlist[j] == 0) ? "R4 sweep" :
                              (rlist[j] == 255) ? "R6 sweep" : "R5 sweep");
      end
    end

    // R3 transmit ignores full reservation
    wr(1'b0, 255);
    fill_to(1);
    step(1, 0, 0, 0, 0, "R3 tx ignores resv");

    // R7 simultaneous requests
    wr(1'b0, 0);
    fill_to(64);
    step(1, 1, 0, 0, 0, "R7 both free");
    fill_to(1);
    step(1, 1, 0, 0, 0, "R7 one left");
    wr(1'b0, 8);
    fill_to(3);
    step(1, 1, 0, 0, 0, "R7 R5 edge after tx");
    fill_to(3);
    step(0, 1, 0, 0, 0, "R5 alone above");

    // R8 release and double release
    wr(1'b0, 0);
    fill_to(59);
    step(0, 0, 1, 2, 0, "R8 rel");
    rd(1'b1, v); chk("R8 free after rel", v, 60 * 4);
    step(0, 0, 1, 2, 0, "R8 rel again");
    rd(1'b1, v); chk("R8 double rel ignored", v, 60 * 4);
    step(1, 0, 0, 0, 0, "R8 reuse lowest");
    // R9 release with grant in the same cycle
    step(1, 0, 1, 3, 0, "R9 rel+gnt");
    rd(1'b1, v); chk("R9 count", v, nfree() * 4);
    step(1, 1, 1, 0, 0, "R9 rel+two gnt");
    rd(1'b1, v); chk("R9 count two", v, nfree() * 4);

    // R10 soft reset keeps reservation, denies requests
    wr(1'b0, 16'h20);
    fill_to(10);
    step(1, 1, 0, 0, 1, "R10 req in srst");
    rd(1'b1, v); chk("R10 all free", v, 256);
    rd(1'b0, v); chk("R10 resv kept", v, 16'h0220);

    // R11 upper byte read only, select 1 not writable
    wr(1'b0, 16'hAB10);
    rd(1'b0, v); chk("R11 upper ro", v, 16'h0210);
    wr_en = 1'b1; wr_sel = 1'b1; wr_data = 16'h0055;
    @(negedge clk);
    wr_en = 1'b0;
    rd(1'b0, v); chk("R11 sel1 ignored", v, 16'h0210);
    rd(1'b1, v); chk("R11 free untouched", v, 256);

    // R12 no response without request
    step(0, 0, 0, 0, 0, "R12 idle");
    chk("R12 no tx resp", int'(tx_gnt | tx_deny), 0);
    chk("R12 no rx resp", int'(rx_gnt | rx_deny), 0);

    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  end

  initial begin
    #(20 * 190000);
    nerr++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  end
endmodule